// File: doc/BRIEF.md
# Nibble-Packed Allocation Tag Writer

This block stores 4-bit allocation tags into a byte-wide tag memory. Every 16-byte data granule owns one tag, and every tag byte carries two neighbouring granules: the even granule in the low nibble and the odd granule in the high nibble. A requester issues one of three store kinds on a command port. A single store sets one granule's tag. A pair store sets two consecutive granules to the same tag. A fill store writes one tag over a whole zeroing block.

When only one nibble of a byte changes, the block reads the byte, merges the new nibble and writes the byte back. It faults granule stores whose address is not 16-byte aligned. It drops stores to pages that the surrounding logic reports as untagged. The tag memory is external, with one port and a read latency of one cycle. While `busy` is high, new commands are not accepted.

Top module: `tag_nibble_writer`

## Requirements
- R1: During reset and after it, `busy`, `align_fault` and `mem_en` are low.
- R2: The tag byte for a granule store is `cmd_addr[TAG_AW+4:5]`, and address bits above that slice are ignored. Address bit 4 picks the nibble: 0 selects bits 3:0 and 1 selects bits 7:4.
- R3: A single store (`cmd_op` = 2'b00) on a tagged page replaces only the selected nibble and keeps the other nibble's old value. `busy` stays high for two cycles after acceptance.
- R4: A single or pair store whose `cmd_addr[3:0]` is not zero pulses `align_fault` for one cycle, starting the cycle after acceptance. It writes nothing and does not raise `busy`. This happens whether or not the page is tagged.
- R5: An aligned granule store or a fill store with `page_tagged` low is dropped. There is no memory access, no fault and no busy cycle.
- R6: A pair store (`cmd_op` = 2'b01) with address bit 4 clear makes one write of the tag copied into both nibbles. `busy` is high for one cycle.
- R7: A pair store with address bit 4 set writes the tag into the high nibble of byte N and the low nibble of byte N+1, where N+1 wraps within the tag memory. The other nibble of each byte keeps its old value, and `busy` is high for four cycles.
- R8: A fill store (`cmd_op` = 2'b10) aligns the address down to `BLOCK_BYTES`. It then writes `BLOCK_BYTES/32` consecutive bytes, one per cycle, each holding the tag in both nibbles. Low address bits never raise a fault for a fill.
- R9: A command presented while `busy` is high is ignored.
- R10: Opcode 2'b11 is ignored and has no effect.
- R11: Every tag-memory read is followed in the next cycle by a write to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; accepted when `busy` is low |
| cmd_op | input | 2 | 00 single, 01 pair, 10 fill, 11 ignored |
| cmd_addr | input | 64 | Data address of the store |
| cmd_tag | input | 4 | Tag value to store |
| page_tagged | input | 1 | The addressed page holds tags |
| busy | output | 1 | A store is in progress |
| align_fault | output | 1 | One-cycle pulse for a misaligned granule store |
| mem_en | output | 1 | Tag memory access enable |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | TAG_AW | Tag byte index |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid the cycle after the read |

## Verification
Take the acceptance edge as edge k. A fault appears after edge k and lasts one cycle. A dropped store leaves `busy` low after edge k. A single store's write lands at edge k+2. An aligned pair store's write lands at edge k+1. An unaligned pair store writes at edges k+2 and k+4. A fill store writes at edges k+1 through k+`BLOCK_BYTES/32`.

The bench holds a behavioural count of the busy cycles still due and an expected fault flag, both updated on each rising edge. It compares `busy` and `align_fault` with them on every falling edge. It compares the whole tag memory with a shadow copy only on falling edges where no store is pending, so a byte is never judged while its write is still due.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
   typedef enum logic [1:0] {
      OP_ONE  = 2'b00,
      OP_PAIR = 2'b01,
      OP_FILL = 2'b10,
      OP_NONE = 2'b11
   } tsw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_A,
      ST_WR_A,
      ST_RD_B,
      ST_WR_B,
      ST_PAIR,
      ST_FILL
   } tsw_state_e;

   localparam int GRANULE_LOG = 4;
   localparam int TAGBYTE_LOG = GRANULE_LOG + 1;
endpackage

// File: rtl/tsw_addr_decode.sv
module tsw_addr_decode #(
   parameter int TAG_AW = 12,
   parameter int FB_LOG = 1
) (
   input  logic [TAG_AW+4:0] addr_lo,
   output logic [TAG_AW-1:0] byte_idx,
   output logic              hi_nib,
   output logic              aligned,
   output logic [TAG_AW-1:0] fill_base
);
   assign byte_idx = addr_lo[TAG_AW+4:5];
   assign hi_nib   = addr_lo[4];
   assign aligned  = (addr_lo[3:0] == 4'd0);

   generate
      if (FB_LOG == 0) begin : g_fill_one
         assign fill_base = byte_idx;
      end else begin : g_fill_many
         assign fill_base = {byte_idx[TAG_AW-1:FB_LOG], {FB_LOG{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/tsw_nib_merge.sv
module tsw_nib_merge (
   input  logic [7:0] old_byte,
   input  logic [3:0] tag,
   input  logic       hi,
   output logic [7:0] new_byte
);
   assign new_byte = hi ? {tag, old_byte[3:0]} : {old_byte[7:4], tag};
endmodule

// File: rtl/tsw_fill_seq.sv
module tsw_fill_seq #(
   parameter int FILL_BYTES = 2,
   parameter int CW         = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          advance,
   output logic [CW-1:0] off,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (load)    cnt_q <= '0;
      else if (advance) cnt_q <= cnt_q + CW'(1);
   end

   assign off  = cnt_q;
   assign last = (cnt_q == CW'(FILL_BYTES - 1));
endmodule

// File: rtl/tag_nibble_writer.sv
module tag_nibble_writer #(
   parameter int TAG_AW      = 12,
   parameter int BLOCK_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [63:0]       cmd_addr,
   input  logic [3:0]        cmd_tag,
   input  logic              page_tagged,
   output logic              busy,
   output logic              align_fault,
   output logic              mem_en,
   output logic              mem_we,
   output logic [TAG_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   import tsw_pkg::*;

   localparam int FILL_BYTES = BLOCK_BYTES / 32;
   localparam int FB_LOG     = $clog2(FILL_BYTES);
   localparam int CW         = (FB_LOG > 0) ? FB_LOG : 1;

   generate
      if (BLOCK_BYTES < 32 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two of at least 32");
      end
      if (TAG_AW <= FB_LOG || TAG_AW < 1) begin : g_bad_aw
         $error("TAG_AW must exceed log2 of tag bytes per block");
      end
   endgenerate

   tsw_state_e        state_q, state_d;
   logic [TAG_AW-1:0] idx_q;
   logic [3:0]        tag_q;
   logic              hi_q, split_q, fault_q;

   logic [TAG_AW-1:0] dec_idx, dec_base;
   logic              dec_hi, dec_aligned;
   logic [CW-1:0]     fill_off;
   logic              fill_last;
   logic [7:0]        merged;
   logic              merge_hi;
   logic              accept, misaligned, go;
   tsw_op_e           op;
   logic              unused_addr_hi;

   assign unused_addr_hi = ^cmd_addr[63:TAG_AW+5];
   assign op = tsw_op_e'(cmd_op);

   tsw_addr_decode #(.TAG_AW(TAG_AW), .FB_LOG(FB_LOG)) u_dec (
      .addr_lo   (cmd_addr[TAG_AW+4:0]),
      .byte_idx  (dec_idx),
      .hi_nib    (dec_hi),
      .aligned   (dec_aligned),
      .fill_base (dec_base)
   );

   tsw_fill_seq #(.FILL_BYTES(FILL_BYTES), .CW(CW)) u_fill (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (go && op == OP_FILL),
      .advance (state_q == ST_FILL),
      .off     (fill_off),
      .last    (fill_last)
   );

   assign merge_hi = (state_q == ST_WR_B) ? 1'b0 : hi_q;

   tsw_nib_merge u_merge (
      .old_byte (mem_rdata),
      .tag      (tag_q),
      .hi       (merge_hi),
      .new_byte (merged)
   );

   assign busy       = (state_q != ST_IDLE);
   assign accept     = cmd_valid && !busy && (op != OP_NONE);
   assign misaligned = (op != OP_FILL) && !dec_aligned;
   assign go         = accept && !misaligned && page_tagged;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (go) begin
               unique case (op)
                  OP_ONE:  state_d = ST_RD_A;
                  OP_PAIR: state_d = dec_hi ? ST_RD_A : ST_PAIR;
                  default: state_d = ST_FILL;
               endcase
            end
         end
         ST_RD_A: state_d = ST_WR_A;
         ST_WR_A: state_d = split_q ? ST_RD_B : ST_IDLE;
         ST_RD_B: state_d = ST_WR_B;
         ST_WR_B: state_d = ST_IDLE;
         ST_PAIR: state_d = ST_IDLE;
         ST_FILL: state_d = fill_last ? ST_IDLE : ST_FILL;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         tag_q   <= '0;
         hi_q    <= 1'b0;
         split_q <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         fault_q <= accept && misaligned;
         if (go) begin
            tag_q   <= cmd_tag;
            hi_q    <= dec_hi;
            split_q <= (op == OP_PAIR) && dec_hi;
            idx_q   <= (op == OP_FILL) ? dec_base : dec_idx;
         end
      end
   end

   assign align_fault = fault_q;

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = idx_q;
      mem_wdata = {tag_q, tag_q};
      unique case (state_q)
         ST_RD_A: mem_en = 1'b1;
         ST_WR_A: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = merged;
         end
         ST_RD_B: begin
            mem_en   = 1'b1;
            mem_addr = idx_q + TAG_AW'(1);
         end
         ST_WR_B: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = idx_q + TAG_AW'(1);
            mem_wdata = merged;
         end
         ST_PAIR: begin
            mem_en = 1'b1;
            mem_we = 1'b1;
         end
         ST_FILL: begin
            mem_en   = 1'b1;
            mem_we   = 1'b1;
            mem_addr = idx_q + TAG_AW'(fill_off);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
   parameter int TAG_AW = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [63:0]       cmd_addr,
   input logic              page_tagged,
   input logic              busy,
   input logic              align_fault,
   input logic              mem_en,
   input logic              mem_we,
   input logic [TAG_AW-1:0] mem_addr
);
   logic taken, skewed;
   assign taken  = cmd_valid && !busy && (cmd_op != 2'b11);
   assign skewed = (cmd_op != 2'b10) && (cmd_addr[3:0] != 4'd0);

   assert_misaligned_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      taken && skewed |=> align_fault && !busy && !mem_en);

   assert_fault_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> !busy);

   assert_untagged_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      taken && !skewed && !page_tagged |=> !align_fault && !busy && !mem_en);

   assert_access_within_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> busy);

   assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en && !mem_we |=> mem_en && mem_we && (mem_addr == $past(mem_addr)));
endmodule

bind tag_nibble_writer tsw_checker #(.TAG_AW(TAG_AW)) u_tsw_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_op      (cmd_op),
   .cmd_addr    (cmd_addr),
   .page_tagged (page_tagged),
   .busy        (busy),
   .align_fault (align_fault),
   .mem_en      (mem_en),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr)
);

// File: tb/tb_tag_nibble_writer.sv
module tb_tag_nibble_writer;
   localparam int AW    = 8;
   localparam int BLK   = 128;
   localparam int FB    = BLK / 32;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'b00;
   logic [63:0]   cmd_addr = '0;
   logic [3:0]    cmd_tag = '0;
   logic          page_tagged = 1'b1;
   logic          busy, align_fault, mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata;

   logic [7:0] tmem [DEPTH];
   logic [7:0] sm   [DEPTH];
   int         rem = 0;
   bit         fault_exp = 1'b0;
   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;
   string      cur_req = "R1";
   bit         prev_rd = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   always #10 clk = ~clk;

   tag_nibble_writer #(.TAG_AW(AW), .BLOCK_BYTES(BLK)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .page_tagged(page_tagged),
      .busy(busy), .align_fault(align_fault), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] seed_byte(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   // Tag memory: one port, read data one cycle after the read
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tmem[i] <= seed_byte(i);
         mem_rdata <= '0;
      end else if (mem_en) begin
         if (mem_we) tmem[mem_addr] <= mem_wdata;
         else        mem_rdata <= tmem[mem_addr];
      end
   end

   // Behavioural reference: busy cycles still due, fault flag, shadow tags
   always @(posedge clk) begin
      if (!rst_n) begin
         rem = 0;
         fault_exp = 1'b0;
         for (int i = 0; i < DEPTH; i++) sm[i] = seed_byte(i);
      end else begin
         fault_exp = 1'b0;
         if (rem > 0) rem--;
         else if (cmd_valid && cmd_op != 2'b11) begin
            int idx;
            idx = int'(cmd_addr[AW+4:5]);
            if (cmd_op != 2'b10 && cmd_addr[3:0] != 4'd0) fault_exp = 1'b1;
            else if (page_tagged) begin
               case (cmd_op)
                  2'b00: begin
                     if (cmd_addr[4]) sm[idx][7:4] = cmd_tag;
                     else             sm[idx][3:0] = cmd_tag;
                     rem = 2;
                  end
                  2'b01: begin
                     if (cmd_addr[4]) begin
                        sm[idx][7:4] = cmd_tag;
                        sm[(idx + 1) % DEPTH][3:0] = cmd_tag;
                        rem = 4;
                     end else begin
                        sm[idx] = {cmd_tag, cmd_tag};
                        rem = 1;
                     end
                  end
                  default: begin
                     int base;
                     base = idx & ~(FB - 1);
                     for (int j = 0; j < FB; j++) sm[base + j] = {cmd_tag, cmd_tag};
                     rem = FB;
                  end
               endcase
            end
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(busy == (rem > 0), cur_req, "busy", int'(busy), int'(rem > 0));
         check(align_fault == fault_exp, cur_req, "align_fault", int'(align_fault), int'(fault_exp));
         if (prev_rd)
            check(mem_en && mem_we && mem_addr == prev_addr, "R11", "write after read addr",
                  int'(mem_addr), int'(prev_addr));
         prev_rd   = mem_en && !mem_we;
         prev_addr = mem_addr;
         if (rem == 0) begin
            int bad;
            bad = -1;
            for (int i = 0; i < DEPTH; i++)
               if (bad < 0 && tmem[i] !== sm[i]) bad = i;
            if (bad < 0) check(1'b1, cur_req, "tag memory", 0, 0);
            else check(1'b0, cur_req, $sformatf("tag byte %0d", bad), int'(tmem[bad]), int'(sm[bad]));
         end
      end
   end

   task automatic issue(logic [1:0] op, logic [63:0] addr, logic [3:0] tag, bit pt, string req);
      @(negedge clk);
      cur_req     = req;
      cmd_op      = op;
      cmd_addr    = addr;
      cmd_tag     = tag;
      page_tagged = pt;
      cmd_valid   = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy, "R1", "busy in reset", int'(busy), 0);
      check(!align_fault, "R1", "fault in reset", int'(align_fault), 0);
      check(!mem_en, "R1", "mem_en in reset", int'(mem_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_en, "R1", "idle after reset", int'(busy), 0);

      issue(2'b00, 64'h40, 4'h5, 1'b1, "R3");                   // low nibble of byte 2
      issue(2'b00, 64'h50, 4'hA, 1'b1, "R3");                   // high nibble of byte 2
      issue(2'b00, 64'hFFFF_0000_0000_0060, 4'h6, 1'b1, "R2");  // upper bits ignored
      issue(2'b00, 64'h48, 4'h1, 1'b1, "R4");                   // misaligned single
      issue(2'b01, 64'h104, 4'h2, 1'b0, "R4");                  // misaligned pair, untagged page
      issue(2'b00, 64'h80, 4'h3, 1'b0, "R5");
      issue(2'b01, 64'h200, 4'h7, 1'b1, "R6");
      issue(2'b01, 64'h230, 4'h9, 1'b1, "R7");
      issue(2'b01, 64'h1FF0, 4'hB, 1'b1, "R7");                 // byte 255 then wrap to 0
      issue(2'b10, 64'h1234, 4'hC, 1'b1, "R8");                 // bytes 0x90..0x93
      issue(2'b10, 64'h0F3F, 4'hD, 1'b0, "R5");
      issue(2'b11, 64'h500, 4'hF, 1'b1, "R10");

      // R9: a second command held during a busy single store is ignored
      @(negedge clk);
      cur_req = "R9";
      cmd_op = 2'b00; cmd_addr = 64'h300; cmd_tag = 4'h3; page_tagged = 1'b1; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_op = 2'b01; cmd_addr = 64'h400; cmd_tag = 4'hE;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);

      issue(2'b10, 64'h0, 4'h4, 1'b1, "R8");
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, 1, 0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule